// File: doc/BRIEF.md
# UART FIFO Pair with Transfer-Ready Pins

This block holds the transmit and receive byte queues of one UART channel. It also drives two active-low ready pins that tell a host or an external transfer engine when to move data. The host writes transmit bytes and reads received bytes. The serializer pops transmit bytes, and the deserializer pushes received bytes and raises a one-cycle timeout strobe when received data has sat idle too long.

Two control inputs select one of three pin rules. With the queues disabled, each direction behaves as a single holding register, and the pins report empty or occupied. With the queues enabled and block transfer off, the pins still report empty or occupied, but on 16-entry queues. With block transfer on, the receive pin asks for a burst once a selectable fill level is reached or a timeout occurs, and keeps asking until the queue is drained. In the same mode the transmit pin stays asserted as long as any free slot remains. Block transfer only changes the pin behaviour; the block never masters a bus.

Top module: `uart_fifo_ready`

## Requirements
- R1: After reset both counts are 0, rx_rdy_n is 1, tx_rdy_n is 0 and rx_overrun is 0.
- R2: With fifo_en = 0 each direction holds at most one byte; a host write while the transmit byte is held is ignored (tx_count stays 1); rx_rdy_n is 0 exactly while a received byte is held and tx_rdy_n is 0 exactly while the transmit register is empty.
- R3: With fifo_en = 1 and blk_mode = 0, rx_rdy_n is 0 exactly when rx_count >= 1 and tx_rdy_n is 0 exactly when tx_count = 0.
- R4: With fifo_en = 1 and blk_mode = 1, rx_rdy_n falls in the same cycle that rx_count reaches the level picked by rx_trig_sel: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14 bytes.
- R5: In block mode, a one-cycle rx_timeout pulse while rx_count > 0 drives rx_rdy_n to 0 from the next cycle; a pulse while the receive queue is empty has no effect.
- R6: In block mode, once rx_rdy_n is 0 it stays 0 while host reads bring rx_count below the trigger level, and returns to 1 only in the cycle rx_count becomes 0.
- R7: In block mode, tx_rdy_n is 1 exactly when tx_count = 16 and 0 otherwise.
- R8: Each queue holds up to 16 bytes and returns them in the order written (host_rdata and ser_data show the oldest entry).
- R9: A host write to a full transmit queue and a host read of an empty receive queue are ignored: the counts and the queued contents are unchanged.
- R10: A deserializer push to a full receive queue discards the byte and sets rx_overrun, which stays 1.
- R11: A change of fifo_en empties both queues and clears rx_overrun on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 enables 16-entry queues, 0 selects single holding registers |
| blk_mode | input | 1 | 1 selects block-transfer pin rules (only with fifo_en = 1) |
| rx_trig_sel | input | 2 | Receive fill level: 0=1, 1=4, 2=8, 3=14 bytes |
| host_wr | input | 1 | Host writes host_wdata to the transmit queue |
| host_wdata | input | 8 | Transmit byte from the host |
| host_rd | input | 1 | Host removes the oldest received byte |
| host_rdata | output | 8 | Oldest received byte |
| ser_pop | input | 1 | Serializer removes the oldest transmit byte |
| ser_data | output | 8 | Oldest transmit byte |
| des_push | input | 1 | Deserializer pushes des_data into the receive queue |
| des_data | input | 8 | Received byte from the deserializer |
| rx_timeout | input | 1 | One-cycle receive timeout strobe |
| rx_rdy_n | output | 1 | Receive ready, active low |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| tx_count | output | 5 | Bytes held in the transmit queue |
| rx_count | output | 5 | Bytes held in the receive queue |
| rx_overrun | output | 1 | Sticky flag: a received byte was discarded |

## Verification
The bench targets the receive pin in block mode. It reads the queue down from the trigger level, and a design that released the pin there instead of at empty would show rx_rdy_n going high with data left. It walks all four trigger codes one byte below and at the level, so a wrong level table or an off-by-one compare asserts the pin a byte early or late. It also fires a timeout on an empty queue, which a design that does not gate on occupancy would turn into a stuck low pin. The remaining cases push both queues to 16 and one beyond, where a design that wrapped its pointers would corrupt the order or miscount, and flip fifo_en with data and overrun pending, which must leave nothing behind.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

    typedef enum logic [1:0] {
        RDY_CHAR  = 2'd0,
        RDY_FIFO  = 2'd1,
        RDY_BLOCK = 2'd2
    } rdy_mode_e;

    function automatic rdy_mode_e mode_of(input logic fifo_en, input logic blk);
        if (!fifo_en)
            return RDY_CHAR;
        else if (blk)
            return RDY_BLOCK;
        else
            return RDY_FIFO;
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rdy_fifo.sv
module uart_rdy_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] limit,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          empty, wr_ok, rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count >= limit);
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= bump(wp);
            if (rd_ok) rp <= bump(rp);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && wr_ok)
            mem[wp] <= wr_data;
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en && !flush) |=> (count == $past(count)));

    assert_empty_read_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en && !flush) |=> (count == '0));

endmodule

// File: rtl/uart_rx_ready.sv
module uart_rx_ready
    import uart_rdy_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  rdy_mode_e     mode,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_timeout,
    output logic          rx_rdy_n
);
    logic [CW-1:0] level;
    logic          hold_q, has_data, at_level, burst_on;

    assign level    = CW'(trig_level(trig_sel));
    assign has_data = (rx_count != '0);
    assign at_level = (rx_count >= level);
    assign burst_on = has_data && (at_level || hold_q);

    always_comb begin
        if (mode == RDY_BLOCK)
            rx_rdy_n = !burst_on;
        else
            rx_rdy_n = !has_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else
            hold_q <= (mode == RDY_BLOCK) && has_data && (hold_q || at_level || rx_timeout);
    end

    assert_hold_until_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == RDY_BLOCK && !rx_rdy_n) |=> (mode != RDY_BLOCK || rx_count == '0 || !rx_rdy_n));

    assert_timeout_asserts_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == RDY_BLOCK && rx_timeout && rx_count != '0)
            |=> (mode != RDY_BLOCK || rx_count == '0 || !rx_rdy_n));

endmodule

// File: rtl/uart_tx_ready.sv
module uart_tx_ready
    import uart_rdy_pkg::*;
#(
    parameter int CW = 5
) (
    input  rdy_mode_e     mode,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    output logic          tx_rdy_n
);
    always_comb begin
        if (mode == RDY_BLOCK)
            tx_rdy_n = tx_full;
        else
            tx_rdy_n = (tx_count != '0);
    end
endmodule

// File: rtl/uart_fifo_ready.sv
module uart_fifo_ready
    import uart_rdy_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          blk_mode,
    input  logic [1:0]    rx_trig_sel,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          ser_pop,
    output logic [W-1:0]  ser_data,
    input  logic          des_push,
    input  logic [W-1:0]  des_data,
    input  logic          rx_timeout,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic          rx_overrun
);
    rdy_mode_e     mode;
    logic          fe_q, flush;
    logic [CW-1:0] limit;
    logic          tx_full, rx_full;

    assign mode  = mode_of(fifo_en, blk_mode);
    assign flush = (fifo_en != fe_q);
    assign limit = fifo_en ? CW'(DEPTH) : CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_q       <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            fe_q <= fifo_en;
            if (flush)
                rx_overrun <= 1'b0;
            else if (des_push && rx_full)
                rx_overrun <= 1'b1;
        end
    end

    uart_rdy_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) tx_q_i (
        .clk(clk), .rst(rst), .flush(flush), .limit(limit),
        .wr_en(host_wr), .wr_data(host_wdata), .rd_en(ser_pop),
        .rd_data(ser_data), .count(tx_count), .full(tx_full)
    );

    uart_rdy_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) rx_q_i (
        .clk(clk), .rst(rst), .flush(flush), .limit(limit),
        .wr_en(des_push), .wr_data(des_data), .rd_en(host_rd),
        .rd_data(host_rdata), .count(rx_count), .full(rx_full)
    );

    uart_rx_ready #(.CW(CW)) rx_rdy_i (
        .clk(clk), .rst(rst), .mode(mode), .trig_sel(rx_trig_sel),
        .rx_count(rx_count), .rx_timeout(rx_timeout), .rx_rdy_n(rx_rdy_n)
    );

    uart_tx_ready #(.CW(CW)) tx_rdy_i (
        .mode(mode), .tx_count(tx_count), .tx_full(tx_full), .tx_rdy_n(tx_rdy_n)
    );

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_rdy_n && !tx_rdy_n && !rx_overrun));

    assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(des_push));

    assert_tx_free_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == RDY_BLOCK && tx_count < CW'(DEPTH)) |-> !tx_rdy_n);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tx_count == '0 && rx_count == '0 && !rx_overrun));

endmodule

// File: tb/uart_fifo_ready_tb_top.sv
module uart_fifo_ready_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0, blk_mode = 1'b0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0, ser_pop = 1'b0;
    logic       des_push = 1'b0, rx_timeout = 1'b0;
    logic [7:0] host_wdata = '0, des_data = '0;
    logic [7:0] host_rdata, ser_data;
    logic       rx_rdy_n, tx_rdy_n, rx_overrun;
    logic [4:0] tx_count, rx_count;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_fifo_ready dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .blk_mode(blk_mode),
        .rx_trig_sel(rx_trig_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .ser_pop(ser_pop),
        .ser_data(ser_data), .des_push(des_push), .des_data(des_data),
        .rx_timeout(rx_timeout), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n),
        .tx_count(tx_count), .rx_count(rx_count), .rx_overrun(rx_overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic h_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d; step(); host_wr = 1'b0;
    endtask

    task automatic d_push(input logic [7:0] d);
        des_push = 1'b1; des_data = d; step(); des_push = 1'b0;
    endtask

    task automatic h_read(output logic [7:0] d);
        d = host_rdata; host_rd = 1'b1; step(); host_rd = 1'b0;
    endtask

    task automatic s_pop(output logic [7:0] d);
        d = ser_data; ser_pop = 1'b1; step(); ser_pop = 1'b0;
    endtask

    task automatic set_mode(input logic fe, input logic bm);
        fifo_en = fe; blk_mode = bm; step(); step();
    endtask

    task automatic t_reset();
        check("R1 tx_count", tx_count, 0);
        check("R1 rx_count", rx_count, 0);
        check("R1 rx_rdy_n", rx_rdy_n, 1);
        check("R1 tx_rdy_n", tx_rdy_n, 0);
        check("R1 rx_overrun", rx_overrun, 0);
    endtask

    task automatic t_char_mode();
        logic [7:0] d;
        set_mode(1'b0, 1'b1);
        d_push(8'hA1);
        check("R2 rx_rdy_n held", rx_rdy_n, 0);
        d_push(8'hB2);
        check("R2 rx single slot", rx_count, 1);
        check("R10 overrun char", rx_overrun, 1);
        h_read(d);
        check("R2 rx data", d, 8'hA1);
        check("R2 rx_rdy_n empty", rx_rdy_n, 1);
        h_write(8'h11);
        check("R2 tx_rdy_n held", tx_rdy_n, 1);
        h_write(8'h22);
        check("R2 second write ignored", tx_count, 1);
        s_pop(d);
        check("R2 tx data", d, 8'h11);
        check("R2 tx_rdy_n empty", tx_rdy_n, 0);
    endtask

    task automatic t_switch_flush();
        set_mode(1'b1, 1'b0);
        check("R11 overrun cleared", rx_overrun, 0);
        h_write(8'h31); d_push(8'h41); d_push(8'h42);
        fifo_en = 1'b0; step();
        check("R11 tx emptied", tx_count, 0);
        check("R11 rx emptied", rx_count, 0);
        check("R11 rx_rdy_n", rx_rdy_n, 1);
    endtask

    task automatic t_fifo_mode();
        logic [7:0] d;
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            h_write(8'h50 + 8'(i));
            check("R3 tx_rdy_n occupied", tx_rdy_n, 1);
        end
        for (int i = 0; i < 3; i++) begin
            check("R3 tx_rdy_n before drain", tx_rdy_n, 1);
            s_pop(d);
            check("R8 tx order", d, 8'h50 + i);
        end
        check("R3 tx_rdy_n empty", tx_rdy_n, 0);
        d_push(8'h61); d_push(8'h62);
        check("R3 rx_rdy_n data", rx_rdy_n, 0);
        h_read(d);
        check("R3 rx_rdy_n one left", rx_rdy_n, 0);
        h_read(d);
        check("R8 rx order", d, 8'h62);
        check("R3 rx_rdy_n drained", rx_rdy_n, 1);
        h_read(d);
        check("R9 empty read ignored", rx_count, 0);
        d_push(8'h63);
        h_read(d);
        check("R9 queue intact after empty read", d, 8'h63);
    endtask

    task automatic t_block_trigger();
        int lv[4] = '{1, 4, 8, 14};
        logic [7:0] d;
        set_mode(1'b1, 1'b1);
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            for (int i = 0; i < lv[s] - 1; i++) d_push(8'(i));
            check($sformatf("R4 below level %0d", lv[s]), rx_rdy_n, 1);
            d_push(8'hEE);
            check($sformatf("R4 at level %0d", lv[s]), rx_rdy_n, 0);
            for (int i = 0; i < lv[s]; i++) begin
                check($sformatf("R6 held lvl %0d cnt %0d", lv[s], lv[s] - i), rx_rdy_n, 0);
                h_read(d);
            end
            check($sformatf("R6 release at empty lvl %0d", lv[s]), rx_rdy_n, 1);
        end
    endtask

    task automatic t_block_timeout();
        logic [7:0] d;
        set_mode(1'b1, 1'b1);
        rx_trig_sel = 2'd3;
        rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
        step();
        check("R5 timeout on empty ignored", rx_rdy_n, 1);
        d_push(8'h71);
        check("R5 timeout empty left no latch", rx_rdy_n, 1);
        d_push(8'h72);
        check("R5 below level no timeout", rx_rdy_n, 1);
        rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
        check("R5 timeout asserts", rx_rdy_n, 0);
        h_read(d);
        check("R6 held after timeout", rx_rdy_n, 0);
        h_read(d);
        check("R5 released at empty", rx_rdy_n, 1);
    endtask

    task automatic t_block_tx();
        logic [7:0] d;
        set_mode(1'b1, 1'b1);
        for (int i = 0; i < 15; i++) h_write(8'h80 + 8'(i));
        check("R7 free slot", tx_rdy_n, 0);
        h_write(8'h8F);
        check("R7 full", tx_rdy_n, 1);
        h_write(8'hFF);
        check("R9 write to full ignored", tx_count, 16);
        s_pop(d);
        check("R8 tx head", d, 8'h80);
        check("R7 slot freed", tx_rdy_n, 0);
        for (int i = 1; i < 16; i++) begin
            s_pop(d);
            if (d != 8'h80 + 8'(i)) check("R8 tx order block", d, 8'h80 + i);
        end
        check("R9 dropped byte absent", tx_count, 0);
    endtask

    task automatic t_rx_overflow();
        logic [7:0] d;
        set_mode(1'b0, 1'b0);
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) d_push(8'h90 + 8'(i));
        check("R10 no overrun at 16", rx_overrun, 0);
        d_push(8'hFE);
        check("R10 count capped", rx_count, 16);
        check("R10 overrun set", rx_overrun, 1);
        for (int i = 0; i < 16; i++) begin
            h_read(d);
            if (d != 8'h90 + 8'(i)) check("R8 rx order full", d, 8'h90 + i);
        end
        check("R10 overrun sticky", rx_overrun, 1);
        check("R10 discarded byte absent", rx_count, 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_char_mode();
        t_switch_flush();
        t_fifo_mode();
        t_block_trigger();
        t_block_timeout();
        t_block_tx();
        t_rx_overflow();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule